// File: doc/BRIEF.md
# Weave Field Deinterlacer

This block turns a stream of interlaced video fields into progressive frames by weaving. Each incoming field is written into an on-chip store with one bank per parity. When a field arrives whose parity differs from the field received just before it, the block reads both banks and emits a full-height frame. Even output rows come from the F0 bank and odd rows from the F1 bank. The missing lines are copies of the other field's lines, not interpolated values. With a regular alternating field sequence, this gives one frame for every two fields.

Video enters and leaves on AXI4-Stream style channels. `tuser[0]` marks start of frame and `tuser[1]` gives field parity (0 = F0, 1 = F1). `tlast` ends each line. A static input chooses between interlaced and progressive operation. In progressive operation whole frames are forwarded beat for beat. A parameter inserts a 1024-entry output FIFO.

The controller is a four-state machine:
- IDLE: waits for a start-of-frame beat.
- LOAD: writes a field into its bank.
- EMIT: reads out a woven frame while the input is held off.
- PASS: forwards a progressive frame.

The transitions are:
- IDLE→LOAD: a start beat arrives while interlaced.
- IDLE→PASS: a start beat arrives while progressive.
- LOAD→EMIT: the field ends and completes a pair.
- LOAD→IDLE: the field ends without completing a pair.
- EMIT→IDLE: the last frame beat is accepted downstream.
- PASS→IDLE: the last line's `tlast` is accepted.

Top module: `wv_weave_deint`

## Requirements
- R1: After reset the output valid is low and the input ready is high.
- R2: An interlaced field is FIELD_LINES lines of WIDTH beats each. Its first beat carries `tuser[0]`=1, and `tuser[1]` on that beat gives its parity (0 = F0, 1 = F1). Later beats of the field are placed by count.
- R3: The first field after reset only fills the store and produces no output.
- R4: A field whose parity differs from the previously received field yields a frame of 2×FIELD_LINES lines. Row 2k is line k of the F0 field and row 2k+1 is line k of the F1 field, whichever parity arrived first.
- R5: After a frame is emitted, the pair is used up. The next field only loads, so alternating input gives one frame per two fields.
- R6: Two consecutive fields of equal parity produce no frame. The later one replaces the earlier, and the next opposite-parity field weaves with the newer one.
- R7: On a woven frame, `tlast` is high on every WIDTH-th beat, `tuser[0]` is high only on the first pixel of row 0, and `tuser[1]` is 0.
- R8: While a woven frame is read out, input ready is low for exactly 2×FIELD_LINES×WIDTH cycles when the output never stalls.
- R9: With `i_interlaced`=0, a frame of 2×FIELD_LINES lines (counted by `tlast`) is forwarded unchanged, including `tuser` and `tlast`.
- R10: A beat arriving in IDLE without `tuser[0]` is accepted and discarded.
- R11: With FIFO_EN=1, output back-pressure does not stall the input until the 1024-entry FIFO fills, and a stalled output beat holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_interlaced | input | 1 | 1 = weave fields, 0 = forward progressive frames; change only between frames |
| s_tdata | input | DW | Input pixel |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tlast | input | 1 | Input end of line |
| s_tuser | input | 2 | Bit 0 start of frame, bit 1 field parity |
| m_tdata | output | DW | Output pixel |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts beat |
| m_tlast | output | 1 | Output end of line |
| m_tuser | output | 2 | Bit 0 start of frame, bit 1 parity (0 on woven frames) |

## Verification
The hardest case to reach is the pairing history. Whether a field produces a frame depends on the two fields before it, so it cannot be seen from a single field. The stimulus works through several field sequences:
- F0 then F1.
- A following F0 that must only load.
- A repeated F0 that must replace the stored one.
- A pair that starts with F1.

Each field carries a distinct tag in its pixel values, so a frame built from a stale field miscompares at once. The input stall during readout is measured by offering the next field's first beat immediately after a pair completes. The FIFO case holds the output ready low across a whole progressive frame.

// File: rtl/wv_pkg.sv
package wv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EMIT = 2'd2,
        ST_PASS = 2'd3
    } wv_state_e;
endpackage

// File: rtl/wv_field_store.sv
module wv_field_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/wv_out_fifo.sv
module wv_out_fifo #(
    parameter int PW    = 11,
    parameter int DEPTH = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [PW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [PW-1:0] out_data
);
    localparam int PTW = $clog2(DEPTH);
    localparam int CW  = PTW + 1;

    logic [PW-1:0]  mem [DEPTH];
    logic [PTW-1:0] wr_q, rd_q;
    logic [CW-1:0]  cnt_q;
    logic           push, pop;

    assign in_ready  = (cnt_q != CW'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign out_data  = mem[rd_q];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PTW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PTW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/wv_ctrl.sv
module wv_ctrl
    import wv_pkg::*;
#(
    parameter int DW = 8,
    parameter int W  = 8,
    parameter int FL = 4,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_interlaced,
    input  logic [DW-1:0] s_tdata,
    input  logic          s_tvalid,
    output logic          s_tready,
    input  logic          s_tlast,
    input  logic [1:0]    s_tuser,
    output logic          c_valid,
    input  logic          c_ready,
    output logic [DW-1:0] c_data,
    output logic          c_last,
    output logic [1:0]    c_user,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] mem_raddr,
    input  logic [DW-1:0] mem_rdata,
    output wv_state_e     st
);
    localparam int XW = (W > 1) ? $clog2(W) : 1;
    localparam int RW = (2 * FL > 1) ? $clog2(2 * FL) : 1;

    wv_state_e      st_q, st_d;
    logic [XW-1:0]  x_q;
    logic [RW-1:0]  y_q;
    logic           par_q, prev_valid_q, prev_par_q;
    logic           in_fire, sof, x_end, load_end, emit_end, pass_end, pair;
    logic           wr_par;

    assign st       = st_q;
    assign sof      = s_tuser[0];
    assign in_fire  = s_tvalid && s_tready;
    assign x_end    = (x_q == XW'(W - 1));
    assign load_end = (st_q == ST_LOAD) && s_tvalid && x_end && (y_q == RW'(FL - 1));
    assign emit_end = (st_q == ST_EMIT) && c_ready && x_end && (y_q == RW'(2 * FL - 1));
    assign pass_end = (st_q == ST_PASS) && in_fire && s_tlast && (y_q == RW'(2 * FL - 1));
    assign pair     = prev_valid_q && (prev_par_q != par_q);
    assign wr_par   = (st_q == ST_IDLE) ? s_tuser[1] : par_q;

    assign mem_waddr = AW'(int'(wr_par) * FL * W + int'(y_q) * W + int'(x_q));
    assign mem_raddr = AW'(int'(y_q[0]) * FL * W + int'(y_q >> 1) * W + int'(x_q));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (in_fire && sof) st_d = i_interlaced ? ST_LOAD : ST_PASS;
            ST_LOAD: if (load_end)       st_d = pair ? ST_EMIT : ST_IDLE;
            ST_EMIT: if (emit_end)       st_d = ST_IDLE;
            ST_PASS: if (pass_end)       st_d = ST_IDLE;
            default:                     st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_tready = 1'b1;
        c_valid  = 1'b0;
        c_data   = s_tdata;
        c_last   = s_tlast;
        c_user   = s_tuser;
        mem_we   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (sof && !i_interlaced) begin
                    s_tready = c_ready;
                    c_valid  = s_tvalid;
                end
                mem_we = s_tvalid && sof && i_interlaced;
            end
            ST_LOAD: mem_we = s_tvalid;
            ST_EMIT: begin
                s_tready = 1'b0;
                c_valid  = 1'b1;
                c_data   = mem_rdata;
                c_last   = x_end;
                c_user   = {1'b0, (x_q == '0) && (y_q == '0)};
            end
            ST_PASS: begin
                s_tready = c_ready;
                c_valid  = s_tvalid;
            end
            default: s_tready = 1'b1;
        endcase
    end

    // position counters and pairing history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q          <= '0;
            y_q          <= '0;
            par_q        <= 1'b0;
            prev_valid_q <= 1'b0;
            prev_par_q   <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (in_fire && sof) begin
                    x_q   <= i_interlaced ? XW'(1) : '0;
                    y_q   <= '0;
                    par_q <= s_tuser[1];
                end
                ST_LOAD: if (s_tvalid) begin
                    if (load_end) begin
                        x_q <= '0;
                        y_q <= '0;
                        if (pair) begin
                            prev_valid_q <= 1'b0;
                        end else begin
                            prev_valid_q <= 1'b1;
                            prev_par_q   <= par_q;
                        end
                    end else if (x_end) begin
                        x_q <= '0;
                        y_q <= y_q + 1'b1;
                    end else begin
                        x_q <= x_q + 1'b1;
                    end
                end
                ST_EMIT: if (c_ready) begin
                    if (emit_end) begin
                        x_q <= '0;
                        y_q <= '0;
                    end else if (x_end) begin
                        x_q <= '0;
                        y_q <= y_q + 1'b1;
                    end else begin
                        x_q <= x_q + 1'b1;
                    end
                end
                ST_PASS: if (in_fire && s_tlast) y_q <= pass_end ? '0 : y_q + 1'b1;
                default: x_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/wv_weave_deint.sv
module wv_weave_deint
    import wv_pkg::*;
#(
    parameter int DW      = 8,
    parameter int WIDTH   = 8,
    parameter int FIELD_LINES = 4,
    parameter bit FIFO_EN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_interlaced,
    input  logic [DW-1:0] s_tdata,
    input  logic          s_tvalid,
    output logic          s_tready,
    input  logic          s_tlast,
    input  logic [1:0]    s_tuser,
    output logic [DW-1:0] m_tdata,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic          m_tlast,
    output logic [1:0]    m_tuser
);
    localparam int STORE_DEPTH = 2 * FIELD_LINES * WIDTH;
    localparam int AW          = $clog2(STORE_DEPTH);
    localparam int PW          = DW + 3;
    localparam int FIFO_DEPTH  = 1024;

    wv_state_e     st;
    logic          c_valid, c_ready, c_last, mem_we;
    logic [DW-1:0] c_data, mem_rdata;
    logic [1:0]    c_user;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [PW-1:0] c_pay, m_pay;

    wv_field_store #(.DW(DW), .DEPTH(STORE_DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (s_tdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    wv_ctrl #(.DW(DW), .W(WIDTH), .FL(FIELD_LINES), .AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .i_interlaced (i_interlaced),
        .s_tdata      (s_tdata),
        .s_tvalid     (s_tvalid),
        .s_tready     (s_tready),
        .s_tlast      (s_tlast),
        .s_tuser      (s_tuser),
        .c_valid      (c_valid),
        .c_ready      (c_ready),
        .c_data       (c_data),
        .c_last       (c_last),
        .c_user       (c_user),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_raddr    (mem_raddr),
        .mem_rdata    (mem_rdata),
        .st           (st)
    );

    assign c_pay = {c_user, c_last, c_data};

    generate
        if (FIFO_EN) begin : g_fifo
            wv_out_fifo #(.PW(PW), .DEPTH(FIFO_DEPTH)) u_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (c_valid),
                .in_ready  (c_ready),
                .in_data   (c_pay),
                .out_valid (m_tvalid),
                .out_ready (m_tready),
                .out_data  (m_pay)
            );
        end else begin : g_direct
            assign m_tvalid = c_valid;
            assign c_ready  = m_tready;
            assign m_pay    = c_pay;
        end
    endgenerate

    assign {m_tuser, m_tlast, m_tdata} = m_pay;
endmodule

// File: rtl/wv_weave_chk.sv
module wv_weave_chk
    import wv_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input wv_state_e     st,
    input logic          i_interlaced,
    input logic          s_tready,
    input logic          m_tvalid,
    input logic          m_tready,
    input logic          m_tlast,
    input logic [DW-1:0] m_tdata
);
    AST_EMIT_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_EMIT |-> !s_tready);  // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));  // R11
    AST_EMIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_EMIT |=> st == ST_EMIT || st == ST_IDLE);  // R5
    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE && i_interlaced |-> s_tready);  // R10
    AST_PASS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_PASS |=> st == ST_PASS || st == ST_IDLE);  // R9
endmodule

bind wv_weave_deint wv_weave_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st),
    .i_interlaced (i_interlaced),
    .s_tready     (s_tready),
    .m_tvalid     (m_tvalid),
    .m_tready     (m_tready),
    .m_tlast      (m_tlast),
    .m_tdata      (m_tdata)
);

// File: tb/sim_wv_weave_deint.sv
`timescale 1ns/1ps
module sim_wv_weave_deint;
    localparam int DW = 8;
    localparam int W  = 8;
    localparam int FL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          i_interlaced = 1'b1;
    logic [DW-1:0] s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic          s_tlast = 1'b0;
    logic [1:0]    s_tuser = '0;
    logic [DW-1:0] m_tdata;
    logic          m_tvalid;
    logic          m_tready = 1'b0;
    logic          m_tlast;
    logic [1:0]    m_tuser;

    always #2 clk = ~clk;  // 250 MHz

    wv_weave_deint #(.DW(DW), .WIDTH(W), .FIELD_LINES(FL), .FIFO_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .i_interlaced(i_interlaced),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tlast(s_tlast), .s_tuser(s_tuser),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast), .m_tuser(m_tuser)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_rx  = 0;
    bit hold  = 1'b0;
    bit done  = 1'b0;
    logic [DW+2:0] exp_q[$];
    string         tag_q[$];
    logic [DW-1:0] fmem [2][FL][W];
    bit            pv = 1'b0;
    bit            pp = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every accepted output beat
    initial begin
        forever begin
            @(negedge clk);
            m_tready = hold ? 1'b0 : ($urandom % 4 != 0);
            #1;
            if (rst_n && m_tvalid && m_tready) begin
                n_rx++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 R5 R6 R10 unexpected beat", int'({m_tuser, m_tlast, m_tdata}), 0);
                end else begin
                    logic [DW+2:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({m_tuser, m_tlast, m_tdata} == e, t, int'({m_tuser, m_tlast, m_tdata}), int'(e));
                end
            end
        end
    end

    task automatic drive(input logic [DW-1:0] d, input logic last, input logic [1:0] user,
                         output int stalls);
        @(negedge clk);
        s_tvalid = 1'b1; s_tdata = d; s_tlast = last; s_tuser = user;
        stalls = 0;
        #1;
        while (!s_tready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0; s_tuser = '0;
    endtask

    task automatic send_field(input bit par, input int tag, output int first_stall);
        int st;
        first_stall = 0;
        for (int y = 0; y < FL; y++) begin
            for (int x = 0; x < W; x++) begin
                logic [DW-1:0] d;
                d = DW'(tag * 32 + y * 8 + x);
                fmem[par][y][x] = d;
                drive(d, x == W - 1, {par, (y == 0) && (x == 0)}, st);
                if (y == 0 && x == 0) first_stall = st;
            end
        end
        if (pv && pp != par) begin
            for (int r = 0; r < 2 * FL; r++) begin
                for (int x = 0; x < W; x++) begin
                    exp_q.push_back({1'b0, (r == 0) && (x == 0), x == W - 1, fmem[r % 2][r / 2][x]});
                    tag_q.push_back("R4 R7 woven beat");
                end
            end
            pv = 1'b0;
        end else begin
            pv = 1'b1;
            pp = par;
        end
    endtask

    task automatic send_prog(input int tag, output int total_stall);
        int st;
        total_stall = 0;
        for (int y = 0; y < 2 * FL; y++) begin
            for (int x = 0; x < W; x++) begin
                logic [DW-1:0] d;
                d = DW'(tag * 64 + y * 8 + x);
                exp_q.push_back({1'b0, (y == 0) && (x == 0), x == W - 1, d});
                tag_q.push_back("R9 progressive beat");
                drive(d, x == W - 1, {1'b0, (y == 0) && (x == 0)}, st);
                total_stall += st;
            end
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drain();
        int k = 0;
        while (exp_q.size() != 0 && k < 5000) begin
            @(negedge clk);
            k++;
        end
        wait_cycles(20);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int fs, rx0, tot;
        wait_cycles(5);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(m_tvalid == 1'b0, "R1 valid after reset", int'(m_tvalid), 0);
        check(s_tready == 1'b1, "R1 ready after reset", int'(s_tready), 1);

        // R2 R3: first field only loads
        send_field(1'b0, 1, fs);
        go_idle();
        wait_cycles(80);
        check(n_rx == 0, "R3 no output after first field", n_rx, 0);

        // R4: F0 then F1 weaves; R8: next field stalls during readout
        send_field(1'b1, 2, fs);
        check(fs == 0, "R2 second field accepted at once", fs, 0);
        send_field(1'b0, 3, fs);
        check(fs == 2 * FL * W, "R8 input held during readout", fs, 2 * FL * W);
        go_idle();
        drain();
        check(n_rx == 2 * FL * W, "R5 one frame for three fields", n_rx, 2 * FL * W);

        // R6: repeated parity replaces the stored field
        rx0 = n_rx;
        send_field(1'b0, 4, fs);
        go_idle();
        wait_cycles(80);
        check(n_rx == rx0, "R6 equal parity gives no frame", n_rx - rx0, 0);
        send_field(1'b1, 5, fs);
        go_idle();
        drain();
        check(n_rx == rx0 + 2 * FL * W, "R6 frame uses newer field", n_rx - rx0, 2 * FL * W);

        // R4: pair beginning with F1 still starts row 0 from F0
        send_field(1'b1, 6, fs);
        send_field(1'b0, 7, fs);
        go_idle();
        drain();

        // R10: stray beat in IDLE is dropped
        rx0 = n_rx;
        drive(8'hAA, 1'b0, 2'b00, fs);
        check(fs == 0, "R10 stray beat accepted", fs, 0);
        go_idle();
        wait_cycles(30);
        check(n_rx == rx0, "R10 stray beat not forwarded", n_rx - rx0, 0);

        // R9: progressive pass-through
        i_interlaced = 1'b0;
        send_prog(1, tot);
        go_idle();
        drain();

        // R11: FIFO absorbs a frame while the output is held
        hold = 1'b1;
        wait_cycles(3);
        rx0 = n_rx;
        send_prog(2, tot);
        go_idle();
        check(tot == 0, "R11 no input stall with FIFO", tot, 0);
        wait_cycles(4);
        #1;
        check(m_tvalid == 1'b1, "R11 output waiting", int'(m_tvalid), 1);
        check(m_tdata == exp_q[0][DW-1:0], "R11 held beat value", int'(m_tdata), int'(exp_q[0][DW-1:0]));
        check(n_rx == rx0, "R11 nothing taken while held", n_rx - rx0, 0);
        hold = 1'b0;
        drain();
        check(exp_q.size() == 0, "R4 R9 scoreboard empty", exp_q.size(), 0);
        finish_run();
    end
endmodule